// File: doc/BRIEF.md
# Three-Channel Fan PWM Generator

This block drives three fan-speed outputs. Each output is a pulse-width signal built from a 64-slot period. Each channel has its own 8-bit duty register. Its upper six bits give the number of high slots and its lowest bit forces the output high. One shared 8-bit control register chooses the tick that advances each channel's slot counter. The choices are a slow standby tick, a fast tick, or both together, which doubles the rate. Only channels 0 and 1 can be pinned to the standby tick.

Software reaches the registers over a small synchronous bus: one write strobe, a 2-bit address, write data, and a combinational read port. Addresses 0, 1 and 2 hold the duty registers of channels 0, 1 and 2, and address 3 holds the control register. A new duty value or tick source written during a period is held back until the counter wraps from slot 63 to slot 0. A period therefore always runs to its end with the settings it started with.

Top module: `fan_pwm`

## Requirements
- R1: After reset every duty register reads 0x00, the control register reads 0x30 and all three outputs are low.
- R2: A write to address 0, 1 or 2 sets the duty register of channel 0, 1 or 2, and a write to address 3 sets the control register. Every register reads back the full byte last written.
- R3: With the force bit (duty bit 0) clear and a duty field N (duty bits 6..1), the output is high in slots 0..N-1 and low in slots N..63 of each 64-slot period.
- R4: A duty field of 0 with the force bit clear keeps the output low for the whole period.
- R5: A duty field of 63 with the force bit clear gives 63 high slots and exactly one low slot, slot 63.
- R6: A force bit of 1 holds the output high in every slot, whatever the duty field holds.
- R7: A duty register written during a period changes the output only from the next slot 0. The period in progress finishes with its old value.
- R8: Tick mapping per channel. A set multiplier bit selects both ticks. Otherwise, a set standby bit selects the standby tick. Otherwise, a set select bit selects the fast tick. Otherwise the standby tick is used.
- R9: When a channel uses both ticks, its slot counter advances in every cycle in which either tick input is high.
- R10: Control bit positions. Channel 0 uses select bit 0 and multiplier bit 1. Channel 1 uses select bit 2 and multiplier bit 3. Channel 2 uses select bit 6 and multiplier bit 7. Bits 4 and 5 are the standby bits of channels 0 and 1, and channel 2 has no standby bit.
- R11: A change of tick source takes effect at the next wrap to slot 0, and the slot counter is not cleared when the source changes.
- R12: The slot counter holds its value, and the output stays steady, in any cycle without a step from the channel's selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sby_i | input | 1 | Standby tick enable, one cycle per tick |
| tick_fast_i | input | 1 | Fast tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0..2 duty, 3 control) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| pwm_o | output | 3 | Fan PWM outputs, bit c for channel c |

## Verification
The assertions check, on every cycle, the relations that are local to one period. A forced channel is high. A zero duty field keeps the output low. Slot 63 is never high unless forced, and slot 0 is high for any non-zero field. The counter holds without a step, advances by one on a step, and wraps to zero. The latched duty stays fixed except at a wrap. What only the bench scenarios can show is that the right tick gets chosen from the control bits of each channel. The same goes for writes made mid-period landing at exactly the next boundary, and for full waveform shapes over many periods. The bench's cycle-accurate reference model, which feeds the scoreboard, covers all of these.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    localparam int NCH    = 3;
    localparam int SLOT_W = 6;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int CTRL_ADDR = NCH;

    typedef enum logic [1:0] {
        SRC_SBY  = 2'd0,
        SRC_FAST = 2'd1,
        SRC_BOTH = 2'd2
    } src_e;

    // control register bit positions per channel
    function automatic int sel_bit(input int c);
        return (c == NCH - 1) ? 6 : 2 * c;
    endfunction

    function automatic int mul_bit(input int c);
        return (c == NCH - 1) ? 7 : 2 * c + 1;
    endfunction

    function automatic bit has_sby(input int c);
        return c < NCH - 1;
    endfunction

    function automatic int sby_bit(input int c);
        return has_sby(c) ? 4 + c : 0;
    endfunction

    // multiplier wins, then standby pin, then select bit
    function automatic src_e src_of(input int c, input logic [REG_W-1:0] ctl);
        logic mul_v, sel_v, sby_v;
        mul_v = ctl[mul_bit(c)];
        sel_v = ctl[sel_bit(c)];
        sby_v = has_sby(c) ? ctl[sby_bit(c)] : 1'b0;
        if (mul_v)      return SRC_BOTH;
        else if (sby_v) return SRC_SBY;
        else if (sel_v) return SRC_FAST;
        else            return SRC_SBY;
    endfunction
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter logic [REG_W-1:0] CTRL_INIT = 8'h30
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [REG_W-1:0]                 wdata_i,
    output logic [REG_W-1:0]                 rdata_o,
    output logic [NCH-1:0][SLOT_W:0]         duty_o,
    output logic [REG_W-1:0]                 ctrl_o
);
    typedef struct packed {
        logic [NCH-1:0][REG_W-1:0] duty;
        logic [REG_W-1:0]          ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (int'(addr_i) == CTRL_ADDR)
                st_d.ctrl = wdata_i;
            else if (int'(addr_i) < NCH)
                st_d.duty[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.duty <= '0;
            st_q.ctrl <= CTRL_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(addr_i) == CTRL_ADDR)
            rdata_o = st_q.ctrl;
        else if (int'(addr_i) < NCH)
            rdata_o = st_q.duty[addr_i];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign duty_o[c] = st_q.duty[c][SLOT_W:0];
    end

    assign ctrl_o = st_q.ctrl;
endmodule

// File: rtl/fan_pwm_chan.sv
module fan_pwm_chan
    import fan_pwm_pkg::*;
#(
    parameter src_e SRC_INIT = SRC_SBY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sby_i,
    input  logic              tick_fast_i,
    input  src_e              src_i,
    input  logic [SLOT_W:0]   duty_i,
    output logic              pwm_o,
    output logic              step_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [SLOT_W-1:0] lvl_o,
    output logic              frc_o
);
    localparam logic [SLOT_W-1:0] LAST = '1;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] lvl;
        logic              frc;
        src_e              src;
    } chan_t;

    chan_t st_d, st_q;
    logic  step, wrap;

    always_comb begin
        case (st_q.src)
            SRC_SBY:  step = tick_sby_i;
            SRC_FAST: step = tick_fast_i;
            SRC_BOTH: step = tick_sby_i | tick_fast_i;
            default:  step = 1'b0;
        endcase
        wrap = step && (st_q.slot == LAST);

        st_d = st_q;
        if (step)
            st_d.slot = st_q.slot + 1'b1;
        if (wrap) begin
            st_d.lvl = duty_i[SLOT_W:1];
            st_d.frc = duty_i[0];
            st_d.src = src_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.lvl  <= '0;
            st_q.frc  <= 1'b0;
            st_q.src  <= SRC_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o  = st_q.frc | (st_q.slot < st_q.lvl);
    assign step_o = step;
    assign slot_o = st_q.slot;
    assign lvl_o  = st_q.lvl;
    assign frc_o  = st_q.frc;
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
    import fan_pwm_pkg::*;
#(
    parameter logic [REG_W-1:0] CTRL_RST = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sby_i,
    input  logic              tick_fast_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [NCH-1:0]    pwm_o
);
    logic [NCH-1:0][SLOT_W:0]   duty_w;
    logic [REG_W-1:0]           ctrl_w;
    logic [NCH-1:0]             step_w;
    logic [NCH-1:0]             frc_w;
    logic [NCH-1:0][SLOT_W-1:0] slot_w;
    logic [NCH-1:0][SLOT_W-1:0] lvl_w;

    fan_pwm_regs #(
        .CTRL_INIT (CTRL_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .duty_o  (duty_w),
        .ctrl_o  (ctrl_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        src_e src_c;
        assign src_c = src_of(c, ctrl_w);

        fan_pwm_chan #(
            .SRC_INIT (src_of(c, CTRL_RST))
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_sby_i  (tick_sby_i),
            .tick_fast_i (tick_fast_i),
            .src_i       (src_c),
            .duty_i      (duty_w[c]),
            .pwm_o       (pwm_o[c]),
            .step_o      (step_w[c]),
            .slot_o      (slot_w[c]),
            .lvl_o       (lvl_w[c]),
            .frc_o       (frc_w[c])
        );
    end
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk
    import fan_pwm_pkg::*;
#(
    parameter logic [REG_W-1:0] CTRL_RST = 8'h30
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tick_sby,
    input logic                             tick_fast,
    input logic [NCH-1:0]                   pwm,
    input logic [NCH-1:0]                   step,
    input logic [NCH-1:0][SLOT_W-1:0]       slot,
    input logic [NCH-1:0][SLOT_W-1:0]       lvl,
    input logic [NCH-1:0]                   frc,
    input logic [REG_W-1:0]                 ctrl
);
    localparam logic [SLOT_W-1:0] LAST = '1;

    // R1
    ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl == CTRL_RST));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6
        force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            frc[c] |-> pwm[c]);

        // R4
        zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!frc[c] && lvl[c] == '0) |-> !pwm[c]);

        // R5
        last_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!frc[c] && slot[c] == LAST) |-> !pwm[c]);

        // R3
        first_slot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!frc[c] && lvl[c] != '0 && slot[c] == '0) |-> pwm[c]);

        // R12
        hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !step[c] |=> $stable(slot[c]));

        // R12
        step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            step[c] |-> (tick_sby || tick_fast));

        // R11
        advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step[c] && slot[c] != LAST) |=> (slot[c] == $past(slot[c]) + 1'b1));

        // R11
        wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step[c] && slot[c] == LAST) |=> (slot[c] == '0));

        // R7
        latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(step[c] && slot[c] == LAST) |=> ($stable(lvl[c]) && $stable(frc[c])));
    end
endmodule

bind fan_pwm fan_pwm_chk #(.CTRL_RST(CTRL_RST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_sby  (tick_sby_i),
    .tick_fast (tick_fast_i),
    .pwm       (pwm_o),
    .step      (step_w),
    .slot      (slot_w),
    .lvl       (lvl_w),
    .frc       (frc_w),
    .ctrl      (ctrl_w)
);

// File: tb/sim_fan_pwm.sv
module sim_fan_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ts = 1'b0;
    logic       tf = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] pwm;

    always #10 clk = ~clk;   // 50 MHz

    fan_pwm u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_sby_i  (ts),
        .tick_fast_i (tf),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .pwm_o       (pwm)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // tick pattern: fast every 2nd cycle, standby every 5th
    int cyc = 0;
    bit sby_en = 1'b1;
    bit fast_en = 1'b1;
    always @(negedge clk) begin
        cyc++;
        tf = fast_en && (cyc % 2 == 0);
        ts = sby_en && (cyc % 5 == 0);
    end

    // reference model: 0 standby, 1 fast, 2 both (R8, R10)
    function automatic int mode_of(input int c, input logic [7:0] k);
        logic ml, sl, sb;
        ml = (c == 2) ? k[7] : k[2*c+1];
        sl = (c == 2) ? k[6] : k[2*c];
        sb = (c == 2) ? 1'b0 : k[4+c];
        if (ml) return 2;
        if (sb) return 0;
        if (sl) return 1;
        return 0;
    endfunction

    logic [7:0] m_reg [3];
    logic [7:0] m_ctl;
    logic [5:0] m_slot [3];
    logic [5:0] m_lvl [3];
    logic       m_frc [3];
    int         m_mode [3];

    typedef struct {
        logic [2:0] exp;
        string      t0;
        string      t1;
        string      t2;
    } item_t;
    item_t sbq[$];

    function automatic string tag_of(input int c);
        if (phase != "") return phase;
        if (m_frc[c]) return "R6";
        if (m_lvl[c] == 6'd0) return "R4";
        if (m_lvl[c] == 6'd63) return "R5";
        return "R3";
    endfunction

    always @(posedge clk) begin
        item_t it;
        if (!rst_n) begin
            m_ctl = 8'h30;
            for (int c = 0; c < 3; c++) begin
                m_reg[c] = 8'h00; m_slot[c] = 6'd0; m_lvl[c] = 6'd0;
                m_frc[c] = 1'b0;  m_mode[c] = mode_of(c, 8'h30);
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                bit st;
                st = (m_mode[c] == 2) ? (ts | tf) : (m_mode[c] == 1) ? tf : ts;
                if (st) begin
                    if (m_slot[c] == 6'd63) begin
                        m_slot[c] = 6'd0;
                        m_lvl[c]  = m_reg[c][6:1];
                        m_frc[c]  = m_reg[c][0];
                        m_mode[c] = mode_of(c, m_ctl);
                    end else begin
                        m_slot[c] = m_slot[c] + 6'd1;
                    end
                end
            end
            if (wr_en) begin
                if (addr == 2'd3) m_ctl = wdata;
                else m_reg[addr] = wdata;
            end
        end
        for (int c = 0; c < 3; c++)
            it.exp[c] = m_frc[c] | (m_slot[c] < m_lvl[c]);
        it.t0 = tag_of(0); it.t1 = tag_of(1); it.t2 = tag_of(2);
        sbq.push_back(it);
    end

    // monitor
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            vectors++;
            for (int c = 0; c < 3; c++) begin
                if (pwm[c] !== it.exp[c]) begin
                    miscompares++;
                    $display("FAIL %s: pwm[%0d] got %b expected %b at t=%0t",
                             (c == 0) ? it.t0 : (c == 1) ? it.t1 : it.t2,
                             c, pwm[c], it.exp[c], $time);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string r);
        @(negedge clk);
        addr = a;
        #1;
        vectors++;
        if (rdata !== e) begin
            miscompares++;
            $display("FAIL %s: read addr %0d got %02h expected %02h", r, a, rdata, e);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(2'd0, 8'h00, "R1");
        rd(2'd1, 8'h00, "R1");
        rd(2'd2, 8'h00, "R1");
        rd(2'd3, 8'h30, "R1");
        run(20);

        // R2 writes and readback; R10 all channels on fast tick
        phase = "R2";
        wr(2'd3, 8'h45); rd(2'd3, 8'h45, "R2");
        wr(2'd0, 8'h40); rd(2'd0, 8'h40, "R2");
        wr(2'd1, 8'h7E); rd(2'd1, 8'h7E, "R2");
        wr(2'd2, 8'h01); rd(2'd2, 8'h01, "R2");
        phase = "";
        run(700);   // R3 duty 32, R5 duty 63, R6 force

        // R4 zero duty and N=1 edge of R3; R6 force bit with non-zero field
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h3F);
        run(300);

        // R7 mid-period duty change
        phase = "R7";
        run(37);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'h7E);
        run(260);

        // R10 standby bits win for ch0/ch1, ch2 has none
        phase = "R10";
        wr(2'd3, 8'h75); rd(2'd3, 8'h75, "R10");
        run(700);

        // R9 multiplier on all channels
        phase = "R9";
        wr(2'd3, 8'h8A);
        run(400);

        // R11 source change mid-period, counter kept
        phase = "R11";
        run(23);
        wr(2'd3, 8'h45);
        run(400);

        // R8 mixed mapping: ch0 fast, ch1 standby, ch2 standby
        phase = "R8";
        wr(2'd3, 8'h01); rd(2'd3, 8'h01, "R8");
        run(800);

        // R12 no ticks: counter and outputs frozen, writes do not show
        phase = "R12";
        sby_en = 1'b0; fast_en = 1'b0;
        run(5);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        run(150);
        sby_en = 1'b1; fast_en = 1'b1;
        run(800);

        run(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run got hung, expected to finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule